// File: doc/BRIEF.md
# Banked IRQ/FIQ Interrupt Aggregator

This block gathers 96 level-sensitive interrupt lines, grouped in three banks of 32, into two processor requests. A normal request and a fast request go to the processor. A high level on a line sets a sticky pending bit. The pending bit stays set until software clears it by writing a one to it. Each bank also has a mask register that blocks its lines from both requests. Each bank has a select register that routes its unmasked pending lines to the fast request as well. Each bank has an enable register that software can read and write, but the enable register has no effect on either request.

Software reaches the registers through a simple single-cycle port inside a 1 KiB window. The port carries valid, write, byte address, write data and registered read data. The window also holds four global words: a vector address, a base address, a protection word and an NMI word. Address bits [1:0] are ignored.

Top module: `irqc_top`

## Requirements
- R1: Line n sets bit (n mod 32) of pending bank (n / 32). Pending bank k is read at byte offset 0x10 + 4k. A line that is high at a clock edge sets its bit at that edge. A low line never clears a bit.
- R2: `irq_o` is 1 exactly when some bank has a bit that is pending and not masked. Mask bank k is at 0x50 + 4k. The enable banks at 0x40 + 4k have no effect on `irq_o`.
- R3: `fiq_o` is 1 exactly when some bank has a bit that is pending, selected and not masked. Select bank k is at 0x30 + 4k.
- R4: A write to a pending bank (0x10 + 4k) or to a fast-pending bank (0x20 + 4k) clears each bit where the write data is 1. Every other bit keeps its value. Input lines never set the fast-pending banks.
- R5: Writes to the vector word (0x00) and to the base word (0x04) store the data with bits [1:0] forced to 0. The protection word (0x08) and the NMI word (0x0C) store all 32 bits.
- R6: The select, enable and mask banks are plain read/write registers. Within each group, address bits [3:2] pick bank 0, 1 or 2.
- R7: Reset clears every register to zero. While reset is held and just after it, both requests and the read data are 0.
- R8: A read from an unmapped offset returns 0, and a write to one changes nothing. Unmapped offsets are bank index 3 of any group (such as 0x1C) and anything from 0x60 upward.
- R9: If a line is high in the same cycle that a write clears its pending bit, the bit stays set.
- R10: Read data appears on `rsp_rdata` in the cycle after the read request. It holds that value until the next read. A read returns the register state from before any update at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 96 | Level-sensitive interrupt inputs |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window, bits [1:0] ignored |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two functions can act on the same pending bit at one clock edge: capture from an input line, and a write-one-to-clear from software. The bench holds a line high for exactly the cycle in which it writes a clear to that line's bit. It then reads the bank back and expects the bit to still be set. A second overlap comes from a read that lands in the cycle after a write or a capture. The behavioural reference model updates state only after it has computed the read value. Its expected requests and read data are compared with the design on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_VECTOR,
        REG_BASE,
        REG_PROTECT,
        REG_NMI,
        REG_PEND,
        REG_FPEND,
        REG_SEL,
        REG_EN,
        REG_MASK
    } reg_kind_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_BANKS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [1:0]        bank
);
    localparam int unsigned PAGE_W = ADDR_W - 4;

    logic [PAGE_W-1:0] page;
    reg_kind_e         raw_kind;

    assign page = addr[ADDR_W-1:4];
    assign bank = addr[3:2];

    always_comb begin
        raw_kind = REG_NONE;
        unique case (page)
            PAGE_W'(0): begin
                unique case (addr[3:2])
                    2'd0: raw_kind = REG_VECTOR;
                    2'd1: raw_kind = REG_BASE;
                    2'd2: raw_kind = REG_PROTECT;
                    2'd3: raw_kind = REG_NMI;
                endcase
            end
            PAGE_W'(1): raw_kind = REG_PEND;
            PAGE_W'(2): raw_kind = REG_FPEND;
            PAGE_W'(3): raw_kind = REG_SEL;
            PAGE_W'(4): raw_kind = REG_EN;
            PAGE_W'(5): raw_kind = REG_MASK;
            default:    raw_kind = REG_NONE;
        endcase
    end

    // Banked groups only decode bank indices that exist.
    always_comb begin
        kind = raw_kind;
        if (page != PAGE_W'(0) && 32'(bank) >= NUM_BANKS) begin
            kind = REG_NONE;
        end
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines,
    input  logic [W-1:0] wdata,
    input  logic         clr_pend,
    input  logic         clr_fpend,
    input  logic         we_sel,
    input  logic         we_en,
    input  logic         we_mask,
    output logic [W-1:0] pend,
    output logic [W-1:0] fpend,
    output logic [W-1:0] sel,
    output logic [W-1:0] en,
    output logic [W-1:0] mask,
    output logic         irq_any,
    output logic         fiq_any
);
    logic [W-1:0] pend_kept;

    // Clear first, then capture, so a live line wins over a clear.
    assign pend_kept = clr_pend ? (pend & ~wdata) : pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= '0;
            fpend <= '0;
            sel   <= '0;
            en    <= '0;
            mask  <= '0;
        end else begin
            pend <= pend_kept | lines;
            if (clr_fpend) fpend <= fpend & ~wdata;
            if (we_sel)    sel   <= wdata;
            if (we_en)     en    <= wdata;
            if (we_mask)   mask  <= wdata;
        end
    end

    assign irq_any = |(pend & ~mask);
    assign fiq_any = |(pend & ~mask & sel);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned ADDR_W    = 10,
    localparam int unsigned NUM_LINES = NUM_BANKS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic                 irq_o,
    output logic                 fiq_o
);
    reg_kind_e   kind;
    logic [1:0]  bank;
    logic        wr_en;
    logic        rd_en;

    logic [WORD_W-1:0] vec_q, base_q, prot_q, nmi_q;
    logic [WORD_W-1:0] pend_a  [NUM_BANKS];
    logic [WORD_W-1:0] fpend_a [NUM_BANKS];
    logic [WORD_W-1:0] sel_a   [NUM_BANKS];
    logic [WORD_W-1:0] en_a    [NUM_BANKS];
    logic [WORD_W-1:0] mask_a  [NUM_BANKS];
    logic [NUM_BANKS-1:0] irq_part, fiq_part;
    logic [NUM_LINES-1:0] pend_flat;
    logic [WORD_W-1:0]    rd_val;

    assign wr_en = req_valid &  req_write;
    assign rd_en = req_valid & ~req_write;

    irqc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_decode (
        .addr (req_addr),
        .kind (kind),
        .bank (bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && (bank == 2'(b));

        irqc_bank #(.W(WORD_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lines     (irq_lines[b*WORD_W +: WORD_W]),
            .wdata     (req_wdata),
            .clr_pend  (hit && kind == REG_PEND),
            .clr_fpend (hit && kind == REG_FPEND),
            .we_sel    (hit && kind == REG_SEL),
            .we_en     (hit && kind == REG_EN),
            .we_mask   (hit && kind == REG_MASK),
            .pend      (pend_a[b]),
            .fpend     (fpend_a[b]),
            .sel       (sel_a[b]),
            .en        (en_a[b]),
            .mask      (mask_a[b]),
            .irq_any   (irq_part[b]),
            .fiq_any   (fiq_part[b])
        );

        assign pend_flat[b*WORD_W +: WORD_W] = pend_a[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q  <= '0;
            base_q <= '0;
            prot_q <= '0;
            nmi_q  <= '0;
        end else if (wr_en) begin
            unique case (kind)
                REG_VECTOR:  vec_q  <= {req_wdata[WORD_W-1:2], 2'b00};
                REG_BASE:    base_q <= {req_wdata[WORD_W-1:2], 2'b00};
                REG_PROTECT: prot_q <= req_wdata;
                REG_NMI:     nmi_q  <= req_wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (kind)
            REG_VECTOR:  rd_val = vec_q;
            REG_BASE:    rd_val = base_q;
            REG_PROTECT: rd_val = prot_q;
            REG_NMI:     rd_val = nmi_q;
            default: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (bank == 2'(b)) begin
                        unique case (kind)
                            REG_PEND:  rd_val = pend_a[b];
                            REG_FPEND: rd_val = fpend_a[b];
                            REG_SEL:   rd_val = sel_a[b];
                            REG_EN:    rd_val = en_a[b];
                            REG_MASK:  rd_val = mask_a[b];
                            default:   rd_val = '0;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rsp_rdata <= '0;
        else if (rd_en) rsp_rdata <= rd_val;
    end

    assign irq_o = |irq_part;
    assign fiq_o = |fiq_part;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_LINES = 96,
    parameter int unsigned ADDR_W    = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [31:0]          rsp_rdata,
    input logic                 irq_o,
    input logic                 fiq_o,
    input logic [NUM_LINES-1:0] pend_flat,
    input logic [1:0]           vec_lo
);
    AST_CAPTURE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_lines) |=> ((pend_flat & $past(irq_lines)) == $past(irq_lines))); // R1 R9

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|pend_flat)); // R2

    AST_FIQ_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o); // R3

    AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == '0) |=> (vec_lo == 2'b00)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !fiq_o && pend_flat == '0)); // R7

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'(28)) |=> (rsp_rdata == '0)); // R8

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> $stable(rsp_rdata)); // R10
endmodule

bind irqc_top irqc_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_rdata (rsp_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .pend_flat (pend_flat),
    .vec_lo    (vec_q[1:0])
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;
    localparam int NL = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] lines;
    logic          req_valid, req_write;
    logic [9:0]    req_addr;
    logic [31:0]   req_wdata;
    logic [31:0]   rsp_rdata;
    logic          irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R7";

    logic [31:0] m_pend [NB];
    logic [31:0] m_fpend[NB];
    logic [31:0] m_sel  [NB];
    logic [31:0] m_en   [NB];
    logic [31:0] m_mask [NB];
    logic [31:0] m_vec, m_base, m_prot, m_nmi, m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top u_irqc_top (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [31:0] m_read(input int off);
        int g, k;
        if (off < 16) begin
            if (off == 0) return m_vec;
            if (off == 4) return m_base;
            if (off == 8) return m_prot;
            return m_nmi;
        end
        if (off >= 96) return 32'h0;
        g = off / 16;
        k = (off % 16) / 4;
        if (k >= NB) return 32'h0;
        if (g == 1) return m_pend[k];
        if (g == 2) return m_fpend[k];
        if (g == 3) return m_sel[k];
        if (g == 4) return m_en[k];
        return m_mask[k];
    endfunction

    task automatic m_write(input int off, input logic [31:0] d);
        int g, k;
        if (off < 16) begin
            if (off == 0) m_vec = d & ~32'h3;
            else if (off == 4) m_base = d & ~32'h3;
            else if (off == 8) m_prot = d;
            else m_nmi = d;
            return;
        end
        if (off >= 96) return;
        g = off / 16;
        k = (off % 16) / 4;
        if (k >= NB) return;
        if (g == 1) m_pend[k] = m_pend[k] & ~d;
        else if (g == 2) m_fpend[k] = m_fpend[k] & ~d;
        else if (g == 3) m_sel[k] = d;
        else if (g == 4) m_en[k] = d;
        else m_mask[k] = d;
    endtask

    function automatic logic m_irq();
        logic r = 1'b0;
        for (int k = 0; k < NB; k++) r |= |(m_pend[k] & ~m_mask[k]);
        return r;
    endfunction

    function automatic logic m_fiq();
        logic r = 1'b0;
        for (int k = 0; k < NB; k++) r |= |(m_pend[k] & ~m_mask[k] & m_sel[k]);
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NB; k++) begin
                m_pend[k] = 0; m_fpend[k] = 0; m_sel[k] = 0; m_en[k] = 0; m_mask[k] = 0;
            end
            m_vec = 0; m_base = 0; m_prot = 0; m_nmi = 0; m_rdata = 0;
        end else begin
            int off;
            off = {22'd0, req_addr[9:2], 2'b00};
            if (req_valid && !req_write) m_rdata = m_read(off);
            if (req_valid && req_write) m_write(off, req_wdata);
            for (int n = 0; n < NL; n++) if (lines[n]) m_pend[n / 32][n % 32] = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (irq_o !== m_irq()) begin
                errors++;
                $display("FAIL R2 irq_o actual=%b expected=%b t=%0t", irq_o, m_irq(), $time);
            end
            checks++;
            if (fiq_o !== m_fiq()) begin
                errors++;
                $display("FAIL R3 fiq_o actual=%b expected=%b t=%0t", fiq_o, m_fiq(), $time);
            end
            checks++;
            if (rsp_rdata !== m_rdata) begin
                errors++;
                $display("FAIL %s rsp_rdata actual=%h expected=%h t=%0t", phase, rsp_rdata, m_rdata, $time);
            end
        end
    end

    task automatic tick(input logic v, input logic w, input logic [9:0] a, input logic [31:0] d);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        req_valid = 0; req_write = 0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        tick(1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [9:0] a);
        tick(1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic idle();
        tick(1'b0, 1'b0, 10'h0, 32'h0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        lines = '0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        phase = "R7";
        for (int a = 0; a < 96; a += 4) rd(10'(a));

        phase = "R6";
        for (int k = 0; k < NB; k++) begin
            wr(10'(48 + 4*k), 32'hA5A5_0000 | 32'(k));
            wr(10'(64 + 4*k), 32'h0F0F_1111 << k);
            wr(10'(80 + 4*k), 32'hFFFF_0000 ^ 32'(k * 7));
        end
        for (int a = 48; a < 96; a += 4) rd(10'(a));
        for (int k = 0; k < NB; k++) begin
            wr(10'(48 + 4*k), 32'h0);
            wr(10'(80 + 4*k), 32'h0);
        end

        phase = "R1";
        foreach (lines[n]) begin
            if (n == 0 || n == 31 || n == 32 || n == 63 || n == 64 || n == 95) begin
                lines[n] = 1'b1;
                idle();
                lines = '0;
                idle();
            end
        end
        rd(10'h10); rd(10'h14); rd(10'h18);

        phase = "R2";
        for (int k = 0; k < NB; k++) wr(10'(80 + 4*k), 32'hFFFF_FFFF);
        idle();
        for (int k = 0; k < NB; k++) wr(10'(64 + 4*k), 32'hFFFF_FFFF);
        idle();
        wr(10'h54, 32'h0);
        idle();
        for (int k = 0; k < NB; k++) wr(10'(64 + 4*k), 32'h0);
        idle();

        phase = "R3";
        wr(10'h34, 32'h0000_0001);
        idle();
        wr(10'h30, 32'h0000_0001);
        wr(10'h54, 32'hFFFF_FFFF);
        idle();
        wr(10'h50, 32'h0);
        idle();
        rd(10'h30);

        phase = "R4";
        wr(10'h10, 32'h0000_0001);
        rd(10'h10);
        wr(10'h14, 32'h8000_0000);
        rd(10'h14);
        wr(10'h20, 32'hFFFF_FFFF);
        rd(10'h20);
        for (int k = 0; k < NB; k++) wr(10'(16 + 4*k), 32'hFFFF_FFFF);
        rd(10'h10); rd(10'h14); rd(10'h18);

        phase = "R9";
        lines[5] = 1'b1;
        wr(10'h10, 32'h0000_0020);
        lines = '0;
        rd(10'h10);
        lines[70] = 1'b1;
        wr(10'h18, 32'hFFFF_FFFF);
        lines = '0;
        rd(10'h18);
        for (int k = 0; k < NB; k++) wr(10'(16 + 4*k), 32'hFFFF_FFFF);
        wr(10'h30, 32'h0);

        phase = "R5";
        wr(10'h000, 32'hFFFF_FFFF);
        wr(10'h004, 32'h1234_5677);
        wr(10'h008, 32'hDEAD_BEEF);
        wr(10'h00C, 32'h0000_0003);
        rd(10'h000); rd(10'h004); rd(10'h008); rd(10'h00C);

        phase = "R8";
        wr(10'h01C, 32'hFFFF_FFFF);
        wr(10'h02C, 32'hFFFF_FFFF);
        wr(10'h060, 32'hFFFF_FFFF);
        wr(10'h3FC, 32'hFFFF_FFFF);
        rd(10'h01C); rd(10'h060); rd(10'h3FC);
        for (int a = 0; a < 96; a += 4) rd(10'(a));

        phase = "R10";
        rd(10'h008);
        idle(); idle(); idle();
        rd(10'h004);
        rd(10'h000);
        wr(10'h000, 32'h0000_0040);
        idle();
        rd(10'h000);
        idle();

        finish_run();
    end
endmodule